// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the 13-bit fetch address of a small microcontroller core and picks the next address each clock. The address advances by one in straight-line code, takes a new low byte written from the data bus, takes an 11-bit immediate on a jump or call, or reloads a whole 13-bit return address popped from an external stack. The upper five address bits are never written directly. They come from a separate 5-bit page latch that software loads over the data bus. The latch is copied into the counter only on a low-byte write, which uses all five bits, or on a jump or call, which uses the top two.

The core's decoder drives one request strobe for each source. The unit resolves overlapping strobes by a fixed priority and registers the result. The counter's low byte and the page latch can both be read back. The stack storage, instruction decode and program memory sit outside the block.

Top module: `paged_pc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter and the page latch both become zero, so `pc`, `pcl_rd` and `lat_rd` all read 0.
- R2: With `step` high and no other request, the counter becomes pc+1 modulo 2^13 at the edge, so 0x1FFF wraps to 0x0000.
- R3: `pcl_wr` loads pc[7:0] from `wdata` and pc[12:8] from the page latch value held before that edge, with no carry from the low byte into the upper bits.
- R4: `jmp_req` loads pc[10:0] from `imm` and pc[12:11] from latch bits 4 and 3.
- R5: `ret_req` loads `ret_addr` in full; the page latch plays no part in the result.
- R6: The page latch changes only on `lat_wr`, taking `wdata[4:0]`. A return, jump, low-byte write or step leaves it unchanged. When `lat_wr` and `pcl_wr` share an edge, the low-byte write uses the old latch value.
- R7: Priority when strobes overlap, highest first: `rst`, `ret_req`, `jmp_req`, `pcl_wr`, `step`. With none of them asserted, the counter holds its value.
- R8: `pcl_rd` always equals pc[7:0]. `lat_rd` carries the latch in bits 4:0, and bits 7:5 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Sequential advance request |
| ret_req | input | 1 | Load the popped return address |
| jmp_req | input | 1 | Jump or call with immediate |
| pcl_wr | input | 1 | Write the counter low byte |
| lat_wr | input | 1 | Write the page latch |
| imm | input | 11 | Jump/call immediate |
| wdata | input | 8 | Data bus for low-byte and latch writes |
| ret_addr | input | 13 | Return address from the stack |
| pc | output | 13 | Current fetch address |
| pcl_rd | output | 8 | Readback of pc[7:0] |
| lat_rd | output | 8 | Readback of the page latch, zero-extended |

## Verification
The hardest corner to reach from the ports is the top of the address space. Stepping there would take more than eight thousand cycles. Instead, the stimulus loads latch value 0x18 and jumps to immediate 0x7FF, which lands on 0x1FFF, and then issues one step to check the wrap to zero. A second directed sequence puts the low byte at 0xFF and compares a step, which carries into the upper bits, against a low-byte write, which must not carry. Then the latch write and the low-byte write are placed on the same edge to check that the old latch value is used. After that, long stretches of random overlapping strobes exercise the priority order against the bench model.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD = 3'd0,
    SEL_INC  = 3'd1,
    SEL_PCL  = 3'd2,
    SEL_JMP  = 3'd3,
    SEL_RET  = 3'd4
  } pc_sel_e;
endpackage

// File: rtl/pcu_select.sv
module pcu_select
  import pcu_pkg::*;
(
  input  logic    step,
  input  logic    ret_req,
  input  logic    jmp_req,
  input  logic    pcl_wr,
  output pc_sel_e sel
);
  always_comb begin
    if (ret_req)      sel = SEL_RET;
    else if (jmp_req) sel = SEL_JMP;
    else if (pcl_wr)  sel = SEL_PCL;
    else if (step)    sel = SEL_INC;
    else              sel = SEL_HOLD;
  end
endmodule

// File: rtl/pcu_page_latch.sv
module pcu_page_latch #(
  parameter int LAT_W = 5,
  parameter int RD_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [RD_W-1:0]  wdata,
  output logic [LAT_W-1:0] lat_q,
  output logic [RD_W-1:0]  lat_rd
);
  always_ff @(posedge clk) begin
    if (rst)     lat_q <= '0;
    else if (wr) lat_q <= wdata[LAT_W-1:0];
  end

  generate
    if (RD_W > LAT_W) begin : g_pad
      assign lat_rd = {{(RD_W-LAT_W){1'b0}}, lat_q};
    end else begin : g_nopad
      assign lat_rd = lat_q[RD_W-1:0];
    end
  endgenerate

  // R6: only an explicit latch write may alter the page latch
  a_r6_latch_stable: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(wr)) |-> $stable(lat_q));
  a_r6_latch_load: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr)) |-> lat_q == $past(wdata[LAT_W-1:0]));
  // R8: the padding bits above the latch read as zero
  a_r8_lat_upper_zero: assert property (@(posedge clk)
    lat_rd[RD_W-1:LAT_W] == '0);
endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg
  import pcu_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LO_W  = 8,
  parameter int IMM_W = 11,
  localparam int LAT_W = PC_W - LO_W,
  localparam int JHI_W = PC_W - IMM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  pc_sel_e          sel,
  input  logic [LAT_W-1:0] lat_q,
  input  logic [IMM_W-1:0] imm,
  input  logic [LO_W-1:0]  wdata,
  input  logic [PC_W-1:0]  ret_addr,
  output logic [PC_W-1:0]  pc_q
);
  logic [PC_W-1:0] pc_next;

  always_comb begin
    unique case (sel)
      SEL_RET: pc_next = ret_addr;
      SEL_JMP: pc_next = {lat_q[LAT_W-1 -: JHI_W], imm};
      SEL_PCL: pc_next = {lat_q, wdata};
      SEL_INC: pc_next = pc_q + PC_W'(1);
      default: pc_next = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  // R2: sequential advance wraps at the top of the space
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(sel) == SEL_INC && $past(pc_q) == '1) |-> pc_q == '0);
  // R7: no request leaves the counter unchanged
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(sel) == SEL_HOLD) |-> $stable(pc_q));
  // R3: a low-byte write never leaves the upper bits different from the old latch
  a_r3_no_carry: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(sel) == SEL_PCL) |-> pc_q[PC_W-1:LO_W] == $past(lat_q));
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
  import pcu_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LO_W  = 8,
  parameter int IMM_W = 11,
  localparam int LAT_W = PC_W - LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             ret_req,
  input  logic             jmp_req,
  input  logic             pcl_wr,
  input  logic             lat_wr,
  input  logic [IMM_W-1:0] imm,
  input  logic [LO_W-1:0]  wdata,
  input  logic [PC_W-1:0]  ret_addr,
  output logic [PC_W-1:0]  pc,
  output logic [LO_W-1:0]  pcl_rd,
  output logic [LO_W-1:0]  lat_rd
);
  pc_sel_e          sel;
  logic [LAT_W-1:0] lat_q;

  pcu_select u_sel (
    .step(step), .ret_req(ret_req), .jmp_req(jmp_req), .pcl_wr(pcl_wr), .sel(sel)
  );

  pcu_page_latch #(.LAT_W(LAT_W), .RD_W(LO_W)) u_lat (
    .clk(clk), .rst(rst), .wr(lat_wr), .wdata(wdata), .lat_q(lat_q), .lat_rd(lat_rd)
  );

  pcu_pc_reg #(.PC_W(PC_W), .LO_W(LO_W), .IMM_W(IMM_W)) u_pc (
    .clk(clk), .rst(rst), .sel(sel), .lat_q(lat_q), .imm(imm),
    .wdata(wdata), .ret_addr(ret_addr), .pc_q(pc)
  );

  assign pcl_rd = pc[LO_W-1:0];

  // R5 and R7: a return wins over every other request
  a_r5_ret_wins: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ret_req)) |-> pc == $past(ret_addr));
  // R4: a jump takes the top two latch bits above the immediate
  a_r4_jump: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(jmp_req) && !$past(ret_req)) |->
      (pc[IMM_W-1:0] == $past(imm) && pc[PC_W-1:IMM_W] == $past(lat_rd[LAT_W-1 -: PC_W-IMM_W])));
  // R1: reset clears the counter and the latch
  a_r1_reset: assert property (@(posedge clk) $past(rst) |-> (pc == '0 && lat_rd == '0));
endmodule

// File: tb/paged_pc_unit_test.sv
module paged_pc_unit_test;
  logic        clk = 1'b0;
  logic        rst, step, ret_req, jmp_req, pcl_wr, lat_wr;
  logic [10:0] imm;
  logic [7:0]  wdata;
  logic [12:0] ret_addr;
  logic [12:0] pc;
  logic [7:0]  pcl_rd, lat_rd;

  int vectors = 0;
  int errors  = 0;
  int m_pc  = 0;
  int m_lat = 0;
  string m_tag = "R1";

  always #10 clk = ~clk;

  paged_pc_unit uut (
    .clk(clk), .rst(rst), .step(step), .ret_req(ret_req), .jmp_req(jmp_req),
    .pcl_wr(pcl_wr), .lat_wr(lat_wr), .imm(imm), .wdata(wdata),
    .ret_addr(ret_addr), .pc(pc), .pcl_rd(pcl_rd), .lat_rd(lat_rd)
  );

  // behavioural reference model
  always @(posedge clk) begin
    int new_lat;
    new_lat = lat_wr ? (int'(wdata) % 32) : m_lat;
    if (rst) begin
      m_pc = 0; new_lat = 0; m_tag = "R1";
    end else if (ret_req) begin
      m_pc = int'(ret_addr); m_tag = "R5/R7";
    end else if (jmp_req) begin
      m_pc = (m_lat / 8) * 2048 + int'(imm); m_tag = "R4/R7";
    end else if (pcl_wr) begin
      m_pc = m_lat * 256 + int'(wdata); m_tag = "R3/R6";
    end else if (step) begin
      m_pc = (m_pc + 1) % 8192; m_tag = "R2";
    end else begin
      m_tag = "R7";
    end
    m_lat = new_lat;
  end

  task automatic compare();
    vectors++;
    if (int'(pc) != m_pc) begin
      errors++;
      $display("FAIL %s pc actual=%h expected=%h", m_tag, pc, m_pc);
    end
    if (int'(pcl_rd) != m_pc % 256) begin
      errors++;
      $display("FAIL R8 pcl_rd actual=%h expected=%h", pcl_rd, m_pc % 256);
    end
    if (int'(lat_rd) != m_lat) begin
      errors++;
      $display("FAIL R6/R8 lat_rd actual=%h expected=%h", lat_rd, m_lat);
    end
  endtask

  task automatic drive(input logic s, r, j, p, l, input int im, wd, ra);
    step = s; ret_req = r; jmp_req = j; pcl_wr = p; lat_wr = l;
    imm = 11'(im); wdata = 8'(wd); ret_addr = 13'(ra);
    @(negedge clk);
    compare();
  endtask

  initial begin
    rst = 1'b1;
    drive(1, 1, 1, 1, 1, 'h7AB, 'hFF, 'h1234);
    drive(0, 0, 0, 0, 0, 0, 0, 0);       // R1 reset state
    rst = 1'b0;
    drive(1, 0, 0, 0, 0, 0, 0, 0);       // R2 step
    drive(0, 0, 0, 0, 1, 0, 'hF8, 0);    // R6 latch <- 0x18, upper bits dropped
    drive(0, 0, 1, 0, 0, 'h7FF, 0, 0);   // R4 jump to 0x1FFF
    drive(1, 0, 0, 0, 0, 0, 0, 0);       // R2 wrap to 0
    drive(0, 0, 0, 0, 1, 'h0, 'h05, 0);  // R6 latch <- 5
    drive(0, 0, 0, 1, 0, 0, 'hFF, 0);    // R3 pc = 0x5FF
    drive(1, 0, 0, 0, 0, 0, 0, 0);       // R2 carry into upper bits: 0x600
    drive(0, 0, 0, 1, 1, 0, 'hFF, 0);    // R3/R6 same edge: old latch 5, no carry
    drive(0, 0, 0, 1, 0, 0, 'h00, 0);    // R3 latch now 0x1F
    drive(0, 1, 0, 0, 0, 0, 0, 'h0ABC);  // R5 return ignores latch
    drive(0, 1, 1, 1, 1, 'h123, 'h02, 'h1111); // R7 return wins, R6 latch written
    drive(1, 0, 1, 1, 0, 'h456, 'h33, 0);      // R7 jump over pcl/step
    drive(1, 0, 0, 1, 0, 0, 'h77, 0);          // R7 pcl over step
    drive(0, 0, 0, 0, 0, 0, 0, 0);             // R7 hold
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      drive(r < 60, r % 11 == 0, r % 7 == 0, r % 5 == 0, r % 3 == 0,
            int'($urandom_range(0, 2047)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 8191)));
      if (i == 2000) begin
        rst = 1'b1;
        drive(1, 0, 0, 0, 0, 0, 0, 0);   // R1 mid-run reset
        rst = 1'b0;
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule